// File: doc/BRIEF.md
# Tagged Boot Stream Loader

This block fills memory from a stream of 32-bit boot words. Words arrive on a valid/ready input. The stream is a series of blocks, and every block starts with a pair of header words. The first header word carries the block kind, a 3-bit owner ID and a 16-bit word count. The second header word carries the destination word address. The engine compares the owner ID with the local ID that was sampled at reset. For a block that belongs to it, the engine writes either the payload words from the stream or runs of zeros to a word-addressed write port, which has its own valid/ready handshake. Blocks that belong to other owners are drained from the stream without being stored.

The stream ends with a final block that loads the low boot region, addresses 0x00 to 0xFF. The first four words of this block are kept in holding registers, and the other 252 words are written first. The held words go to 0x00-0x03 only after those writes, so the code that runs the loader is replaced last. When every write has been accepted, the engine raises a one-cycle start pulse with start address zero and clears busy.

Top module: `boot_stream_loader`

## Requirements
- R1: After reset, busy is 1, start, error and wr_en are 0, and in_ready is 1.
- R2: The first header word is decoded as kind in bits 31:30 (0 final, 1 payload, 2 zero-fill, 3 illegal), owner ID in bits 29:27 and COUNT in bits 15:0. The second header word is the destination; only its low ADDR_W bits are used. For a kind-1 block with a matching ID, COUNT stream words are written in order to destination, destination+1 and so on, with the address wrapping at ADDR_W bits.
- R3: A kind-2 block with a matching ID writes COUNT zero words from the destination onward and takes no payload words from the stream. The next stream word is read as a header.
- R4: A block whose owner ID differs from the local ID causes no writes. Kind 1 drains COUNT stream words, kind 0 drains 255 stream words, and kind 2 drains none.
- R5: A kind-1 or kind-2 block with COUNT 0 ends at once, with no writes and no payload consumed.
- R6: A matching kind-0 block takes 256 words. Its words 4..255 are written to addresses 4..255 in order, then its words 0..3 are written to addresses 0..3. After the last write is accepted, start pulses for exactly one cycle with start_addr 0, busy is 0 from that cycle on, and no further words are consumed.
- R7: A kind-3 header pair sets error, which stays set. in_ready stays 0, no further writes are issued, and start never pulses.
- R8: While wr_en is 1 and wr_ready is 0, in_ready is 0 and wr_addr and wr_data hold their values until the write is accepted.
- R9: The local ID is the value of local_id during reset. Changes on local_id after reset have no effect.
- R10: Header bits 26:16 and destination bits above ADDR_W are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| local_id | input | 3 | Local owner ID, sampled during reset |
| in_valid | input | 1 | Boot word valid |
| in_data | input | 32 | Boot word |
| in_ready | output | 1 | Engine accepts the boot word |
| wr_en | output | 1 | Memory write request |
| wr_addr | output | ADDR_W | Memory word address |
| wr_data | output | 32 | Memory write data |
| wr_ready | input | 1 | Memory accepts the write |
| start | output | 1 | One-cycle start-execution pulse |
| start_addr | output | ADDR_W | Start address, always zero |
| busy | output | 1 | High from reset until start |
| error | output | 1 | Illegal block kind seen; engine halted |

## Verification
The bench covers several corner cases, and each one shows up as a particular failure. A skipped final block with the wrong drain length (256 instead of 255) makes every later header decode one word off. A zero-fill block that consumed payload would eat the next header. Blocks with COUNT 0 are included: an engine that treated COUNT 0 as 65536 would hang or flood the write port. Reserved header bits are set to ones, the destination is placed near the address wrap, and local_id is changed right after reset. Each of these catches a decoder that reads the wrong bits or samples the ID late. Random stalls on the write port catch an engine that drops or repeats words under backpressure, and the exact write order of the final block catches an engine that overwrites 0x00-0x03 early or pulses start before the last write is accepted.

// File: rtl/boot_stream_loader.sv
module boot_stream_loader #(
  parameter int ADDR_W      = 16,
  parameter int FINAL_WORDS = 256,
  parameter int HOLD_WORDS  = 4,
  parameter int SKIP_FINAL  = 255
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        local_id,
  input  logic              in_valid,
  input  logic [31:0]       in_data,
  output logic              in_ready,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [31:0]       wr_data,
  input  logic              wr_ready,
  output logic              start,
  output logic [ADDR_W-1:0] start_addr,
  output logic              busy,
  output logic              error
);
  localparam int FIDX_W = $clog2(FINAL_WORDS);
  localparam int HIDX_W = $clog2(HOLD_WORDS);

  typedef enum logic [3:0] {
    S_HDR0, S_HDR1, S_DATA, S_SKIP, S_ZERO, S_FINAL, S_PATCH, S_DRAIN, S_DONE, S_ERR
  } state_t;

  state_t            state, after_hdr;
  logic [2:0]        id_q, blk_id;
  logic [1:0]        kind;
  logic [15:0]       cnt;
  logic [ADDR_W-1:0] ptr;
  logic [FIDX_W-1:0] fidx;
  logic [31:0]       hold [HOLD_WORDS];
  logic              can_wr, take, match;

  assign can_wr     = !wr_en || wr_ready;
  assign in_ready   = can_wr && (state == S_HDR0 || state == S_HDR1 || state == S_DATA ||
                                 state == S_SKIP || state == S_FINAL);
  assign take       = in_valid && in_ready;
  assign match      = (blk_id == id_q);
  assign busy       = (state != S_DONE);
  assign error      = (state == S_ERR);
  assign start_addr = '0;

  always_comb begin
    unique case (kind)
      2'd0:    after_hdr = match ? S_FINAL : S_SKIP;
      2'd1:    after_hdr = (cnt == 16'd0) ? S_HDR0 : (match ? S_DATA : S_SKIP);
      2'd2:    after_hdr = (cnt == 16'd0 || !match) ? S_HDR0 : S_ZERO;
      default: after_hdr = S_ERR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_HDR0;
      id_q    <= local_id;
      blk_id  <= '0;
      kind    <= '0;
      cnt     <= '0;
      ptr     <= '0;
      fidx    <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      start   <= 1'b0;
      for (int i = 0; i < HOLD_WORDS; i++) hold[i] <= '0;
    end else begin
      start <= 1'b0;
      if (wr_ready) wr_en <= 1'b0;
      unique case (state)
        S_HDR0: if (take) begin
          kind   <= in_data[31:30];
          blk_id <= in_data[29:27];
          cnt    <= in_data[15:0];
          state  <= S_HDR1;
        end
        S_HDR1: if (take) begin
          ptr   <= in_data[ADDR_W-1:0];
          fidx  <= '0;
          if (kind == 2'd0 && !match) cnt <= 16'(SKIP_FINAL);
          state <= after_hdr;
        end
        S_DATA: if (take) begin
          wr_en   <= 1'b1;
          wr_addr <= ptr;
          wr_data <= in_data;
          ptr     <= ptr + 1'b1;
          cnt     <= cnt - 16'd1;
          if (cnt == 16'd1) state <= S_HDR0;
        end
        S_SKIP: if (take) begin
          cnt <= cnt - 16'd1;
          if (cnt == 16'd1) state <= S_HDR0;
        end
        S_ZERO: if (can_wr) begin
          wr_en   <= 1'b1;
          wr_addr <= ptr;
          wr_data <= '0;
          ptr     <= ptr + 1'b1;
          cnt     <= cnt - 16'd1;
          if (cnt == 16'd1) state <= S_HDR0;
        end
        S_FINAL: if (take) begin
          if (fidx < FIDX_W'(HOLD_WORDS)) begin
            hold[fidx[HIDX_W-1:0]] <= in_data;
          end else begin
            wr_en   <= 1'b1;
            wr_addr <= ADDR_W'(fidx);
            wr_data <= in_data;
          end
          fidx <= fidx + 1'b1;
          if (fidx == FIDX_W'(FINAL_WORDS - 1)) begin
            fidx  <= '0;
            state <= S_PATCH;
          end
        end
        S_PATCH: if (can_wr) begin
          wr_en   <= 1'b1;
          wr_addr <= ADDR_W'(fidx);
          wr_data <= hold[fidx[HIDX_W-1:0]];
          fidx    <= fidx + 1'b1;
          if (fidx == FIDX_W'(HOLD_WORDS - 1)) state <= S_DRAIN;
        end
        S_DRAIN: if (can_wr) begin
          start <= 1'b1;
          state <= S_DONE;
        end
        default: ;
      endcase
    end
  end

  // R8: a stalled write keeps its payload and blocks the input
  a_r8_write_held: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_ready |=> wr_en && $stable(wr_addr) && $stable(wr_data));
  a_r8_ready_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_ready |-> !in_ready);
  // R6: start is a single pulse that coincides with busy falling
  a_r6_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);
  a_r6_start_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
  a_r6_busy_fall_start: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> start);
  a_r6_done_no_input: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !in_ready);
  // R7: error is sticky and halts all traffic
  a_r7_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> error);
  a_r7_error_halted: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> !in_ready && !start && busy);
  a_r7_error_no_new_write: assert property (@(posedge clk) disable iff (!rst_n)
    error && $past(error) && !$past(wr_en) |-> !wr_en);
endmodule

// File: tb/tb_boot_stream_loader.sv
module tb_boot_stream_loader;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    local_id = '0;
  logic          in_valid = 1'b0;
  logic [31:0]   in_data = '0;
  logic          in_ready;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [31:0]   wr_data;
  logic          wr_ready = 1'b0;
  logic          start;
  logic [AW-1:0] start_addr;
  logic          busy;
  logic          error;

  always #2.5 clk = ~clk;

  boot_stream_loader #(.ADDR_W(AW)) dut (.*);

  int checks = 0, fails = 0;
  logic [31:0]   stream [4096];
  int            slen;
  logic [AW-1:0] exp_addr [4096];
  logic [31:0]   exp_data [4096];
  string         exp_req [4096];
  int            nexp;
  logic [2:0]    lid;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  function automatic logic [31:0] hdr(input logic [1:0] k, input logic [2:0] id,
                                      input logic [15:0] c, input logic [10:0] rsv);
    return {k, id, rsv, c};
  endfunction

  task automatic push(input logic [31:0] w);
    stream[slen] = w;
    slen++;
  endtask

  task automatic expect_wr(input logic [AW-1:0] a, input logic [31:0] d, input string r);
    exp_addr[nexp] = a;
    exp_data[nexp] = d;
    exp_req[nexp]  = r;
    nexp++;
  endtask

  task automatic add_block(input logic [1:0] k, input logic [2:0] id, input logic [15:0] c,
                           input logic [31:0] dest, input logic [10:0] rsv, input string r);
    logic [31:0] w;
    logic [31:0] fin [256];
    bit m;
    m = (id == lid);
    push(hdr(k, id, c, rsv));
    push(dest);
    if (k == 2'd1) begin
      for (int i = 0; i < int'(c); i++) begin
        w = $urandom;
        push(w);
        if (m) expect_wr(AW'(dest[AW-1:0] + AW'(i)), w, r);
      end
    end else if (k == 2'd2) begin
      if (m) for (int i = 0; i < int'(c); i++) expect_wr(AW'(dest[AW-1:0] + AW'(i)), 32'd0, r);
    end else if (k == 2'd0) begin
      if (m) begin
        for (int i = 0; i < 256; i++) begin
          fin[i] = $urandom;
          push(fin[i]);
        end
        for (int i = 4; i < 256; i++) expect_wr(AW'(i), fin[i], "R6");
        for (int i = 0; i < 4; i++) expect_wr(AW'(i), fin[i], "R6");
      end else begin
        for (int i = 0; i < 255; i++) push($urandom);
      end
    end
  endtask

  task automatic run(input bit want_err, input int err_pos, input string sreq);
    int pos = 0, nwr = 0, starts = 0, after = 0;
    bit pend = 1'b0;
    logic [AW-1:0] pa;
    logic [31:0] pd;
    rst_n = 1'b0; local_id = lid; in_valid = 1'b0; wr_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    local_id = lid ^ 3'b101;
    #1;
    check(busy === 1'b1 && start === 1'b0 && error === 1'b0 && wr_en === 1'b0 && in_ready === 1'b1,
          "R1", "reset outputs", {busy, start, error, wr_en, in_ready}, 5'b10001);
    for (int cyc = 0; cyc < 30000; cyc++) begin
      @(negedge clk);
      in_valid = (pos < slen) && ($urandom_range(9) < 7);
      in_data  = (pos < slen) ? stream[pos] : 32'hx;
      wr_ready = ($urandom_range(9) < 6);
      #1;
      if (pend) check(wr_en && wr_addr == pa && wr_data == pd, "R8", "held write",
                      {wr_addr, wr_data}, {pa, pd});
      if (wr_en && !wr_ready) check(!in_ready, "R8", "ready under stall", 64'(in_ready), 64'd0);
      pend = wr_en && !wr_ready;
      pa = wr_addr; pd = wr_data;
      if (wr_en && wr_ready) begin
        if (nwr < nexp)
          check(wr_addr == exp_addr[nwr] && wr_data == exp_data[nwr], exp_req[nwr], "write",
                {wr_addr, wr_data}, {exp_addr[nwr], exp_data[nwr]});
        else check(1'b0, sreq, "unexpected write", {wr_addr, wr_data}, 64'd0);
        nwr++;
      end
      if (start) begin
        starts++;
        check(nwr == nexp && start_addr == '0 && !busy, "R6", "start after last write",
              {32'(nwr), 16'(start_addr), 16'(busy)}, {32'(nexp), 32'd0});
      end
      if (in_valid && in_ready) pos++;
      if (starts > 0 || (want_err && error)) after++;
      if (after >= 20) break;
    end
    in_valid = 1'b0;
    check(nwr == nexp, sreq, "write count", 64'(nwr), 64'(nexp));
    if (want_err) begin
      check(error && !in_ready && busy && starts == 0, "R7", "halted on illegal kind",
            {error, in_ready, busy, 32'(starts)}, {3'b101, 32'd0});
      check(pos == err_pos, "R7", "words consumed", 64'(pos), 64'(err_pos));
    end else begin
      check(starts == 1 && !busy, "R6", "single start", {32'(starts), 32'(busy)}, {32'd1, 32'd0});
      check(pos == slen, "R4", "stream fully consumed", 64'(pos), 64'(slen));
    end
  endtask

  initial begin
    #4000000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [1:0] k;
    void'($urandom(32'd20240611));
    // directed stream
    lid = 3'd2; slen = 0; nexp = 0;
    add_block(2'd1, 3'd2, 16'd3, 32'h0000_0100, 11'd0, "R2");
    add_block(2'd2, 3'd2, 16'd2, 32'h0000_0200, 11'd0, "R3");
    add_block(2'd1, 3'd7, 16'd2, 32'h0000_0300, 11'd0, "R4");
    add_block(2'd2, 3'd7, 16'd5, 32'h0000_0300, 11'd0, "R4");
    add_block(2'd1, 3'd2, 16'd0, 32'h0000_0400, 11'd0, "R5");
    add_block(2'd2, 3'd2, 16'd0, 32'h0000_0400, 11'd0, "R5");
    add_block(2'd1, lid ^ 3'b101, 16'd3, 32'h0000_0500, 11'd0, "R9");
    add_block(2'd1, 3'd2, 16'd4, 32'hABCD_FFFE, 11'h7FF, "R10");
    add_block(2'd0, 3'd5, 16'd9, 32'h0000_0000, 11'd0, "R4");
    add_block(2'd0, 3'd2, 16'd0, 32'h0000_0000, 11'h155, "R6");
    run(1'b0, 0, "R5");
    // random streams
    for (int s = 0; s < 5; s++) begin
      lid = 3'($urandom); slen = 0; nexp = 0;
      for (int b = 0; b < 3 + int'($urandom_range(4)); b++) begin
        k = ($urandom_range(9) == 0) ? 2'd0 : 2'($urandom_range(2, 1));
        add_block(k, ($urandom_range(1) == 1) ? lid : 3'($urandom),
                  (k == 2'd0) ? 16'($urandom) : 16'($urandom_range(12)),
                  $urandom, 11'($urandom), k == 2'd2 ? "R3" : "R2");
        if (k == 2'd0 && nexp > 0 && exp_req[nexp-1] == "R6") break;
      end
      if (nexp == 0 || exp_req[nexp-1] != "R6")
        add_block(2'd0, lid, 16'd0, 32'd0, 11'd0, "R6");
      run(1'b0, 0, "R2");
    end
    // illegal kind
    lid = 3'd4; slen = 0; nexp = 0;
    add_block(2'd1, 3'd4, 16'd2, 32'h0000_0040, 11'd0, "R2");
    add_block(2'd3, 3'd4, 16'd2, 32'h0000_0080, 11'd0, "R7");
    add_block(2'd1, 3'd4, 16'd2, 32'h0000_00C0, 11'd0, "R7");
    nexp = 2;
    run(1'b1, 6, "R7");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule